// File: doc/BRIEF.md
# Shared-Bus Byte Transfer Unit

This block moves single bytes among four places: an external input port, an output holding register, a working register and a 512-byte register-file RAM. All of them share one internal byte bus. A 9-bit address register selects the RAM location in use, and it is loaded from a separate address input. On every clock, seven level controls say which source drives the bus and which destinations capture it. An eighth level, the output enable, decides whether the output holding register is presented at the pins. Every register load is a synchronous enable on the single clock.

The seven controls form a control word. Its bit order, from bit 6 down to bit 0, is: address load, RAM read, RAM write, input drive, output load, working load, working drive. The decoder names eight transfer kinds:

- idle: 0000000
- input-to-working: 0001010
- address load: 1000000
- working-to-RAM: 0010001
- working-to-output: 0000101
- RAM-to-working: 0100010
- RAM-to-output: 0100100
- input-to-RAM: 0011000

Any other word is classed as "other". An "other" word still acts according to its individual bits, unless it causes a bus conflict.

There are three bus sources: the input port, the RAM and the working register. Only one may drive the bus. When two or more drive enables are set, the block raises a conflict flag and freezes every register and the RAM for that cycle. When a destination load is requested but no source drives the bus, the destination also keeps its value.

Top module: `bus_xfer_unit`

## Requirements
- R1: While reset is low, the working register, the output holding register and the address register are cleared. After reset, with the output enable high, `dout` reads 0x00.
- R2: When the address-load bit is set and there is no bus conflict, the address register takes `mem_addr` at the rising edge. RAM reads and writes that follow use that location.
- R3: Word 0001010 copies `din` into the working register at the rising edge.
- R4: Word 0010001 writes the working register into the RAM location selected by the address register.
- R5: Word 0100010 copies the selected RAM byte into the working register. Word 0100100 copies it into the output holding register. The RAM read is combinational from the address register.
- R6: Word 0011000 writes `din` into the selected RAM location.
- R7: Word 0000101 copies the working register into the output holding register. The holding register keeps its value across cycles in which its load bit is clear.
- R8: `dout_valid` equals the output enable. `dout` shows the holding register while the enable is high and reads 0x00 while it is low.
- R9: `bus_conflict` is high, combinationally, whenever two or more of input drive, RAM read and working drive are set. In such a cycle the working register, the output register, the address register and the RAM are all left unchanged.
- R10: A working load, output load or RAM write requested while none of the three sources drives the bus leaves its destination unchanged.
- R11: `ctl_unlisted` is high for any control word other than all-zero and the seven listed words. For those eight words it is low.
- R12: All 512 locations are distinct. Writes to address 0x1FF and to address 0x000 are read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all loads occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_ld_en | input | 1 | Load the address register from `mem_addr` |
| ram_rd_en | input | 1 | RAM drives the bus with the selected byte |
| ram_wr_en | input | 1 | Write the bus into the selected RAM byte |
| in_drv_en | input | 1 | Input port drives the bus |
| out_ld_en | input | 1 | Load the output holding register from the bus |
| wreg_ld_en | input | 1 | Load the working register from the bus |
| wreg_drv_en | input | 1 | Working register drives the bus |
| out_oe | input | 1 | Present the output holding register on `dout` |
| din | input | 8 | Input port byte |
| mem_addr | input | 9 | Address value for the address register |
| dout | output | 8 | Output port byte; 0x00 when not enabled |
| dout_valid | output | 1 | High while `dout` is driven |
| bus_conflict | output | 1 | More than one bus source is enabled |
| ctl_unlisted | output | 1 | The control word is not idle and not one of the seven transfers |

## Verification
The bench writes to the top and bottom RAM addresses back to back. A design that truncated the address or mirrored locations would return the wrong byte for one of them. Conflict cycles set every load bit at once. A design that resolved the contention by priority instead of freezing would corrupt the working register, the output register, the address register or the RAM, and each of these is later read back through the output port. Loads that have no bus source, and output-enable toggling on a held output value, catch designs that capture a floating bus or that forget the held byte while the port is disabled.

// File: rtl/bxu_pkg.sv
package bxu_pkg;

    parameter int DATA_W = 8;
    parameter int ADDR_W = 9;
    parameter int CTL_W  = 7;

    // Bus source indices
    localparam int NSRC     = 3;
    localparam int SRC_IN   = 0;
    localparam int SRC_RAM  = 1;
    localparam int SRC_WREG = 2;

    // Control word bit positions (the decoder relies on this order)
    localparam int CB_ADDR_LD = 6;
    localparam int CB_RAM_RD  = 5;
    localparam int CB_RAM_WR  = 4;
    localparam int CB_IN_DRV  = 3;
    localparam int CB_OUT_LD  = 2;
    localparam int CB_WREG_LD = 1;
    localparam int CB_WREG_DR = 0;

    localparam logic [CTL_W-1:0] CW_IDLE    = 7'b0000000;
    localparam logic [CTL_W-1:0] CW_IN2W    = 7'b0001010;
    localparam logic [CTL_W-1:0] CW_ADDR    = 7'b1000000;
    localparam logic [CTL_W-1:0] CW_W2RAM   = 7'b0010001;
    localparam logic [CTL_W-1:0] CW_W2OUT   = 7'b0000101;
    localparam logic [CTL_W-1:0] CW_RAM2W   = 7'b0100010;
    localparam logic [CTL_W-1:0] CW_RAM2OUT = 7'b0100100;
    localparam logic [CTL_W-1:0] CW_IN2RAM  = 7'b0011000;

    typedef enum logic [3:0] {
        XK_IDLE,
        XK_IN2W,
        XK_ADDR,
        XK_W2RAM,
        XK_W2OUT,
        XK_RAM2W,
        XK_RAM2OUT,
        XK_IN2RAM,
        XK_OTHER
    } xfer_kind_e;

endpackage

// File: rtl/bxu_ctl_decode.sv
module bxu_ctl_decode
    import bxu_pkg::*;
#(
    parameter int CW = CTL_W
) (
    input  logic [CW-1:0] ctl_word,
    output logic          unlisted
);

    xfer_kind_e kind;

    always_comb begin
        unique case (ctl_word)
            CW_IDLE:    kind = XK_IDLE;
            CW_IN2W:    kind = XK_IN2W;
            CW_ADDR:    kind = XK_ADDR;
            CW_W2RAM:   kind = XK_W2RAM;
            CW_W2OUT:   kind = XK_W2OUT;
            CW_RAM2W:   kind = XK_RAM2W;
            CW_RAM2OUT: kind = XK_RAM2OUT;
            CW_IN2RAM:  kind = XK_IN2RAM;
            default:    kind = XK_OTHER;
        endcase
    end

    assign unlisted = (kind == XK_OTHER);

endmodule

// File: rtl/bxu_bus_mux.sv
module bxu_bus_mux
    import bxu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NSRC
) (
    input  logic [N-1:0]        src_en,
    input  logic [N-1:0][W-1:0] src_data,
    output logic [W-1:0]        bus_data,
    output logic                bus_driven,
    output logic                bus_conflict
);

    logic [W-1:0] masked [N];

    for (genvar g = 0; g < N; g++) begin : g_src
        assign masked[g] = src_en[g] ? src_data[g] : '0;
    end

    always_comb begin
        bus_data = '0;
        for (int i = 0; i < N; i++) begin
            bus_data = bus_data | masked[i];
        end
    end

    assign bus_driven   = $onehot(src_en);
    assign bus_conflict = ($countones(src_en) > 1);

endmodule

// File: rtl/bxu_regfile.sv
module bxu_regfile #(
    parameter int W  = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/bus_xfer_unit.sv
module bus_xfer_unit
    import bxu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_ld_en,
    input  logic          ram_rd_en,
    input  logic          ram_wr_en,
    input  logic          in_drv_en,
    input  logic          out_ld_en,
    input  logic          wreg_ld_en,
    input  logic          wreg_drv_en,
    input  logic          out_oe,
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] mem_addr,
    output logic [DW-1:0] dout,
    output logic          dout_valid,
    output logic          bus_conflict,
    output logic          ctl_unlisted
);

    logic [CTL_W-1:0]        ctl_word;
    logic [AW-1:0]           addr_q;
    logic [DW-1:0]           wreg_q;
    logic [DW-1:0]           out_q;
    logic [DW-1:0]           ram_rdata;
    logic [DW-1:0]           bus_data;
    logic                    bus_driven;
    logic [NSRC-1:0]         src_en;
    logic [NSRC-1:0][DW-1:0] src_data;
    logic                    ld_addr;
    logic                    ld_wreg;
    logic                    ld_out;
    logic                    ram_we;

    // Control word in fixed bit order
    always_comb begin
        ctl_word             = '0;
        ctl_word[CB_ADDR_LD] = addr_ld_en;
        ctl_word[CB_RAM_RD]  = ram_rd_en;
        ctl_word[CB_RAM_WR]  = ram_wr_en;
        ctl_word[CB_IN_DRV]  = in_drv_en;
        ctl_word[CB_OUT_LD]  = out_ld_en;
        ctl_word[CB_WREG_LD] = wreg_ld_en;
        ctl_word[CB_WREG_DR] = wreg_drv_en;
    end

    bxu_ctl_decode #(.CW(CTL_W)) u_dec (
        .ctl_word (ctl_word),
        .unlisted (ctl_unlisted)
    );

    // Bus sources
    always_comb begin
        src_en           = '0;
        src_en[SRC_IN]   = in_drv_en;
        src_en[SRC_RAM]  = ram_rd_en;
        src_en[SRC_WREG] = wreg_drv_en;
        src_data           = '0;
        src_data[SRC_IN]   = din;
        src_data[SRC_RAM]  = ram_rdata;
        src_data[SRC_WREG] = wreg_q;
    end

    bxu_bus_mux #(.W(DW), .N(NSRC)) u_bus (
        .src_en       (src_en),
        .src_data     (src_data),
        .bus_data     (bus_data),
        .bus_driven   (bus_driven),
        .bus_conflict (bus_conflict)
    );

    // Load enables: a conflict freezes all, a missing source blocks data loads
    assign ld_addr = addr_ld_en & ~bus_conflict;
    assign ld_wreg = wreg_ld_en & bus_driven;
    assign ld_out  = out_ld_en  & bus_driven;
    assign ram_we  = ram_wr_en  & bus_driven;

    bxu_regfile #(.W(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (addr_q),
        .wdata (bus_data),
        .rdata (ram_rdata)
    );

    // Register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wreg_q <= '0;
            out_q  <= '0;
        end else begin
            if (ld_addr) addr_q <= mem_addr;
            if (ld_wreg) wreg_q <= bus_data;
            if (ld_out)  out_q  <= bus_data;
        end
    end

    // Output process
    always_comb begin
        dout_valid = out_oe;
        dout       = out_oe ? out_q : '0;
    end

endmodule

// File: rtl/bxu_checker.sv
module bxu_checker #(
    parameter int DW = 8,
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_ld_en,
    input logic          ram_rd_en,
    input logic          in_drv_en,
    input logic          out_ld_en,
    input logic          wreg_ld_en,
    input logic          wreg_drv_en,
    input logic [DW-1:0] din,
    input logic [AW-1:0] mem_addr,
    input logic          bus_conflict,
    input logic [AW-1:0] addr_q,
    input logic [DW-1:0] wreg_q,
    input logic [DW-1:0] out_q,
    input logic [DW-1:0] ram_rdata
);

    a_r1_reset_clears: assert property (@(posedge clk)
        $rose(rst_n) |-> (wreg_q == '0 && out_q == '0 && addr_q == '0));

    a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ld_en && !bus_conflict) |=> (addr_q == $past(mem_addr)));

    a_r3_wreg_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        (wreg_ld_en && in_drv_en && !ram_rd_en && !wreg_drv_en) |=> (wreg_q == $past(din)));

    a_r5_out_from_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ld_en && ram_rd_en && !in_drv_en && !wreg_drv_en) |=> (out_q == $past(ram_rdata)));

    a_r7_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ld_en |=> $stable(out_q));

    a_r9_conflict_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        bus_conflict |=> ($stable(wreg_q) && $stable(out_q) && $stable(addr_q)));

    a_r10_no_source_keeps_wreg: assert property (@(posedge clk) disable iff (!rst_n)
        (wreg_ld_en && !in_drv_en && !ram_rd_en && !wreg_drv_en) |=> $stable(wreg_q));

endmodule

bind bus_xfer_unit bxu_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_ld_en   (addr_ld_en),
    .ram_rd_en    (ram_rd_en),
    .in_drv_en    (in_drv_en),
    .out_ld_en    (out_ld_en),
    .wreg_ld_en   (wreg_ld_en),
    .wreg_drv_en  (wreg_drv_en),
    .din          (din),
    .mem_addr     (mem_addr),
    .bus_conflict (bus_conflict),
    .addr_q       (addr_q),
    .wreg_q       (wreg_q),
    .out_q        (out_q),
    .ram_rdata    (ram_rdata)
);

// File: tb/bus_xfer_unit_tb_top.sv
`timescale 1ns/1ps
module bus_xfer_unit_tb_top;

    localparam logic [6:0] W_IDLE    = 7'b0000000;
    localparam logic [6:0] W_IN2W    = 7'b0001010;
    localparam logic [6:0] W_ADDR    = 7'b1000000;
    localparam logic [6:0] W_W2RAM   = 7'b0010001;
    localparam logic [6:0] W_W2OUT   = 7'b0000101;
    localparam logic [6:0] W_RAM2W   = 7'b0100010;
    localparam logic [6:0] W_RAM2OUT = 7'b0100100;
    localparam logic [6:0] W_IN2RAM  = 7'b0011000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ctl = '0;
    logic       oe = 1'b0;
    logic [7:0] din = '0;
    logic [8:0] maddr = '0;
    logic       addr_ld_en, ram_rd_en, ram_wr_en, in_drv_en;
    logic       out_ld_en, wreg_ld_en, wreg_drv_en;
    logic [7:0] dout;
    logic       dout_valid, bus_conflict, ctl_unlisted;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    assign {addr_ld_en, ram_rd_en, ram_wr_en, in_drv_en,
            out_ld_en, wreg_ld_en, wreg_drv_en} = ctl;

    always #2 clk = ~clk;

    bus_xfer_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_ld_en   (addr_ld_en),
        .ram_rd_en    (ram_rd_en),
        .ram_wr_en    (ram_wr_en),
        .in_drv_en    (in_drv_en),
        .out_ld_en    (out_ld_en),
        .wreg_ld_en   (wreg_ld_en),
        .wreg_drv_en  (wreg_drv_en),
        .out_oe       (oe),
        .din          (din),
        .mem_addr     (maddr),
        .dout         (dout),
        .dout_valid   (dout_valid),
        .bus_conflict (bus_conflict),
        .ctl_unlisted (ctl_unlisted)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply a word at a falling edge, return at the next falling edge
    task automatic step(input logic [6:0] w, input logic [7:0] d, input logic [8:0] a, input logic e);
        ctl = w; din = d; maddr = a; oe = e;
        @(negedge clk);
    endtask

    task automatic peek_wreg(input logic [7:0] exp, input string tag);
        step(W_W2OUT, 8'h00, 9'h000, 1'b1);
        check({24'h0, dout}, {24'h0, exp}, tag);
    endtask

    task automatic peek_ram(input logic [8:0] a, input logic [7:0] exp, input string tag);
        step(W_ADDR, 8'h00, a, 1'b1);
        step(W_RAM2OUT, 8'h00, 9'h000, 1'b1);
        check({24'h0, dout}, {24'h0, exp}, tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        ctl = W_IDLE; oe = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({24'h0, dout}, 32'h0, "R1 output register cleared");
        check({31'h0, dout_valid}, 32'h1, "R8 valid follows enable high");
        peek_wreg(8'h00, "R1 working register cleared");
        step(W_RAM2W, 8'h00, 9'h000, 1'b0);
        check({31'h0, dout_valid}, 32'h0, "R8 valid low when disabled");
        check({24'h0, dout}, 32'h0, "R8 dout zero when disabled");
    endtask

    task automatic t_paths();
        step(W_IN2W, 8'hA5, 9'h000, 1'b0);
        peek_wreg(8'hA5, "R3 input to working");
        step(W_ADDR, 8'h00, 9'h1FF, 1'b0);
        step(W_IN2RAM, 8'h3C, 9'h000, 1'b0);
        step(W_ADDR, 8'h00, 9'h000, 1'b0);
        step(W_IN2RAM, 8'hC3, 9'h1FF, 1'b0);
        peek_ram(9'h1FF, 8'h3C, "R12 top location distinct");
        peek_ram(9'h000, 8'hC3, "R2 R6 bottom location");
        step(W_RAM2W, 8'h00, 9'h000, 1'b0);
        peek_wreg(8'hC3, "R5 RAM to working");
        step(W_IN2W, 8'h5A, 9'h000, 1'b0);
        step(W_ADDR, 8'h00, 9'h055, 1'b0);
        step(W_W2RAM, 8'h00, 9'h000, 1'b0);
        peek_ram(9'h055, 8'h5A, "R4 working to RAM");
        peek_ram(9'h1FF, 8'h3C, "R12 top location kept");
    endtask

    task automatic t_hold();
        step(W_IN2W, 8'h77, 9'h000, 1'b0);
        step(W_W2OUT, 8'h00, 9'h000, 1'b1);
        check({24'h0, dout}, 32'h77, "R7 working to output");
        for (int i = 0; i < 4; i++) begin
            step(W_IN2W, 8'(i * 16 + 3), 9'h000, i[0]);
            if (i[0]) check({24'h0, dout}, 32'h77, "R7 output holds");
            else      check({24'h0, dout}, 32'h0, "R8 disabled reads zero");
        end
    endtask

    task automatic t_conflict();
        step(W_IN2W, 8'h11, 9'h000, 1'b0);
        step(W_ADDR, 8'h00, 9'h010, 1'b0);
        step(W_IN2RAM, 8'h22, 9'h000, 1'b0);
        step(W_RAM2OUT, 8'h00, 9'h000, 1'b1);
        ctl = W_IN2W; #0.5;
        check({31'h0, bus_conflict}, 32'h0, "R9 flag low on legal word");
        ctl = 7'b1111110; din = 8'h99; maddr = 9'h020; #0.5;
        check({31'h0, bus_conflict}, 32'h1, "R9 flag input plus RAM");
        @(negedge clk);
        check({24'h0, dout}, 32'h22, "R9 output frozen");
        peek_wreg(8'h11, "R9 working frozen");
        step(W_RAM2OUT, 8'h00, 9'h000, 1'b1);
        check({24'h0, dout}, 32'h22, "R9 address and RAM frozen");
        ctl = 7'b0110001; #0.5;
        check({31'h0, bus_conflict}, 32'h1, "R9 flag RAM plus working");
        @(negedge clk);
        step(W_RAM2OUT, 8'h00, 9'h000, 1'b1);
        check({24'h0, dout}, 32'h22, "R9 RAM not written in conflict");
    endtask

    task automatic t_no_source();
        step(7'b0000010, 8'hEE, 9'h000, 1'b1);
        peek_wreg(8'h11, "R10 working load without source");
        step(7'b0000100, 8'hEE, 9'h000, 1'b1);
        check({24'h0, dout}, 32'h11, "R10 output load without source");
        step(7'b0010000, 8'hEE, 9'h000, 1'b1);
        step(W_RAM2OUT, 8'h00, 9'h000, 1'b1);
        check({24'h0, dout}, 32'h22, "R10 RAM write without source");
    endtask

    task automatic t_unlisted();
        logic [6:0] legal [8];
        logic [6:0] odd [3];
        legal = '{W_IDLE, W_IN2W, W_ADDR, W_W2RAM, W_W2OUT, W_RAM2W, W_RAM2OUT, W_IN2RAM};
        odd   = '{7'b0000010, 7'b1111111, 7'b0100001};
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ctl = legal[i]; #0.5;
            check({31'h0, ctl_unlisted}, 32'h0, "R11 listed word");
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            ctl = odd[i]; #0.5;
            check({31'h0, ctl_unlisted}, 32'h1, "R11 unlisted word");
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_paths();
        t_hold();
        t_conflict();
        t_no_source();
        t_unlisted();
        finish_run();
    end

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule